// File: doc/BRIEF.md
# Inter-Processor Interrupt Target Selector

This block takes one inter-processor interrupt command at a time and works out which of N local interrupt controllers it is aimed at. For every target it compares the command's 8-bit destination against that target's physical ID or logical ID. The comparison depends on the command's addressing mode and on the target's 4-bit logical format nibble. A 2-bit shorthand can override the address and select the sender, everyone, or everyone except the sender. The result is an N-bit delivery mask, and bit i set means target i receives the interrupt.

In lowest-priority delivery the mask is narrowed to a single target. Only targets that match and are enabled qualify. The selector scans them round-robin, starting just after the index it chose last time. The chosen index is kept for the next command.

Commands enter on a valid/ready handshake and the mask leaves on another. The output stage holds one result. `cmd_ready` is high when that stage is empty or is being drained in the same cycle. An accepted command produces its mask on the next clock edge. While `out_valid` is high and `out_ready` is low, the mask is held and no new command is taken. The target configuration pins are plain level inputs, sampled when a command is accepted.

Top module: `ipi_target_select`

## Requirements
- R1: After reset `out_valid` is 0 and the round-robin memory points at index N-1, so the first lowest-priority scan tries index 0 first.
- R2: In physical mode (`cmd_logical`=0) with shorthand 0, target i matches when the destination is 8'hFF or equals its 8-bit ID `tgt_id[8i+:8]`.
- R3: Shorthand 1 (self) selects only the target whose index equals `cmd_src`, regardless of destination and mode.
- R4: Shorthand 2 selects every target; shorthand 3 selects every target except `cmd_src`.
- R5: In logical mode with shorthand 0 and a format nibble of 4'hF (flat), target i matches when its logical ID ANDed with the destination is nonzero.
- R6: In logical mode with shorthand 0 and a format nibble of 4'h0 (cluster), target i matches when the upper nibbles of logical ID and destination are equal and their lower nibbles share a set bit.
- R7: In logical mode with shorthand 0, a target whose format nibble is neither 4'hF nor 4'h0 never matches.
- R8: With `cmd_lowest`=1 the mask has exactly one bit. That bit is the first index after the previously chosen one, wrapping from N-1 to 0, whose target both matches and has `tgt_enable` set. That index becomes the new remembered choice.
- R9: With `cmd_lowest`=1 and no qualifying target, the mask is all zero and the remembered index is unchanged.
- R10: An accepted command's mask appears with `out_valid`=1 after one clock edge. While `out_valid`=1 and `out_ready`=0, `cmd_ready` is 0 and `out_mask` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when high with cmd_valid |
| cmd_dest | input | 8 | Destination field |
| cmd_logical | input | 1 | 0 physical, 1 logical addressing |
| cmd_shorthand | input | 2 | 0 none, 1 self, 2 all, 3 all but self |
| cmd_lowest | input | 1 | Lowest-priority delivery, reduce to one target |
| cmd_src | input | IDXW | Index of the sending target |
| tgt_id | input | 8*N | Physical ID per target |
| tgt_ldr | input | 8*N | Logical ID per target |
| tgt_fmt | input | 4*N | Logical format nibble per target |
| tgt_enable | input | N | Target may take lowest-priority delivery |
| out_valid | output | 1 | Delivery mask valid |
| out_ready | input | 1 | Consumer takes the mask |
| out_mask | output | N | Delivery mask, bit i for target i |

## Verification
Directed commands try each addressing path in isolation. Physical broadcast is told apart from an exact ID hit. Flat and cluster logical matching are checked on targets that differ only in the format nibble, and a stray nibble must produce no hit. Each shorthand is applied with a destination that would otherwise select other targets, so an override that leaks the address shows up. Lowest-priority sequences check the wrap from the last index to zero, skipping of disabled or non-matching targets, and the empty case that must leave the rotation untouched. Random commands over random target tables, mixed with a stalled output, compare each mask with a model kept in the bench.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;
  typedef enum logic [1:0] {
    SH_NONE    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL     = 2'd2,
    SH_ALLBUT  = 2'd3
  } shorthand_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;
endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
  import ipi_match_pkg::*;
(
  input  logic [7:0] dest,
  input  logic       logical,
  input  logic [1:0] shorthand,
  input  logic       is_src,
  input  logic [7:0] my_id,
  input  logic [7:0] my_ldr,
  input  logic [3:0] my_fmt,
  output logic       hit
);
  logic phys_hit;
  logic flat_hit;
  logic clus_hit;
  logic log_hit;
  logic addr_hit;

  always_comb begin
    phys_hit = (dest == DEST_BCAST) || (dest == my_id);
    flat_hit = |(my_ldr & dest);
    clus_hit = (my_ldr[7:4] == dest[7:4]) && (|(my_ldr[3:0] & dest[3:0]));
    unique case (my_fmt)
      FMT_FLAT:    log_hit = flat_hit;
      FMT_CLUSTER: log_hit = clus_hit;
      default:     log_hit = 1'b0;
    endcase
    addr_hit = logical ? log_hit : phys_hit;
  end

  always_comb begin
    unique case (shorthand_e'(shorthand))
      SH_NONE:   hit = addr_hit;
      SH_SELF:   hit = is_src;
      SH_ALL:    hit = 1'b1;
      SH_ALLBUT: hit = !is_src;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_TGT = 8,
  localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic [N_TGT-1:0] cand,
  input  logic [IDXW-1:0]  last,
  output logic [N_TGT-1:0] pick_mask,
  output logic [IDXW-1:0]  pick_idx,
  output logic             found
);
  always_comb begin
    pick_mask = '0;
    pick_idx  = last;
    found     = 1'b0;
    // scan from farthest to nearest so the nearest candidate wins
    for (int k = N_TGT; k >= 1; k--) begin
      int unsigned j;
      j = (int'(last) + k) % N_TGT;
      if (cand[j]) begin
        pick_mask    = '0;
        pick_mask[j] = 1'b1;
        pick_idx     = IDXW'(j);
        found        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ipi_target_select.sv
module ipi_target_select #(
  parameter int N_TGT = 8,
  localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_dest,
  input  logic                 cmd_logical,
  input  logic [1:0]           cmd_shorthand,
  input  logic                 cmd_lowest,
  input  logic [IDXW-1:0]      cmd_src,
  input  logic [8*N_TGT-1:0]   tgt_id,
  input  logic [8*N_TGT-1:0]   tgt_ldr,
  input  logic [4*N_TGT-1:0]   tgt_fmt,
  input  logic [N_TGT-1:0]     tgt_enable,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N_TGT-1:0]     out_mask
);
  localparam logic [IDXW-1:0] LAST_RST = IDXW'(N_TGT - 1);

  logic [N_TGT-1:0] match_w;
  logic [N_TGT-1:0] cand_w;
  logic [N_TGT-1:0] pick_mask;
  logic [IDXW-1:0]  pick_idx;
  logic             pick_found;
  logic [IDXW-1:0]  last_q;
  logic [N_TGT-1:0] next_mask;
  logic             accept;

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    ipi_addr_match u_match (
      .dest      (cmd_dest),
      .logical   (cmd_logical),
      .shorthand (cmd_shorthand),
      .is_src    (cmd_src == IDXW'(g)),
      .my_id     (tgt_id[8*g +: 8]),
      .my_ldr    (tgt_ldr[8*g +: 8]),
      .my_fmt    (tgt_fmt[4*g +: 4]),
      .hit       (match_w[g])
    );
  end

  assign cand_w = match_w & tgt_enable;

  ipi_rr_pick #(.N_TGT(N_TGT)) u_pick (
    .cand      (cand_w),
    .last      (last_q),
    .pick_mask (pick_mask),
    .pick_idx  (pick_idx),
    .found     (pick_found)
  );

  assign cmd_ready = !out_valid || out_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign next_mask = cmd_lowest ? pick_mask : match_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      last_q    <= LAST_RST;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_mask  <= next_mask;
        if (cmd_lowest && pick_found) last_q <= pick_idx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_target_select_chk.sv
module ipi_target_select_chk #(
  parameter int N_TGT = 8,
  localparam int IDXW = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_shorthand,
  input logic             cmd_lowest,
  input logic [IDXW-1:0]  cmd_src,
  input logic [N_TGT-1:0] tgt_enable,
  input logic [N_TGT-1:0] match_w,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N_TGT-1:0] out_mask
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  // R10: stalled output blocks input and holds its mask
  a_r10_block_in: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !cmd_ready);
  a_r10_hold_mask: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_mask));

  // R8: lowest-priority result is a single qualifying target or nothing
  a_r8_one_target: assert property (@(posedge clk) disable iff (rst)
    take && cmd_lowest |=> $onehot0(out_mask));
  a_r8_qualified: assert property (@(posedge clk) disable iff (rst)
    take && cmd_lowest |=> (out_mask & ~($past(match_w) & $past(tgt_enable))) == '0);

  // R3: self shorthand hits the sender only
  a_r3_self_only: assert property (@(posedge clk) disable iff (rst)
    take && !cmd_lowest && cmd_shorthand == 2'd1
      |=> out_mask == (N_TGT'(1) << $past(cmd_src)));

  // R4: all-but-self shorthand hits everyone except the sender
  a_r4_all_but: assert property (@(posedge clk) disable iff (rst)
    take && !cmd_lowest && cmd_shorthand == 2'd3
      |=> out_mask == ~(N_TGT'(1) << $past(cmd_src)));
endmodule

bind ipi_target_select ipi_target_select_chk #(.N_TGT(N_TGT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_shorthand (cmd_shorthand),
  .cmd_lowest    (cmd_lowest),
  .cmd_src       (cmd_src),
  .tgt_enable    (tgt_enable),
  .match_w       (match_w),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_mask      (out_mask)
);

// File: tb/test_ipi_target_select.sv
`timescale 1ns/1ps
module test_ipi_target_select;
  localparam int N    = 8;
  localparam int IDXW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [7:0]      cmd_dest = '0;
  logic            cmd_logical = 1'b0;
  logic [1:0]      cmd_shorthand = '0;
  logic            cmd_lowest = 1'b0;
  logic [IDXW-1:0] cmd_src = '0;
  logic [8*N-1:0]  tgt_id = '0;
  logic [8*N-1:0]  tgt_ldr = '0;
  logic [4*N-1:0]  tgt_fmt = '0;
  logic [N-1:0]    tgt_enable = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [N-1:0]    out_mask;

  int n_chk = 0;
  int n_bad = 0;
  int rr_last = N - 1;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipi_target_select #(.N_TGT(N)) i_ipi_target_select (.*);

  function automatic bit ref_hit(int t);
    logic [7:0] ldr;
    logic [3:0] fmt;
    bit is_src;
    ldr = tgt_ldr[8*t +: 8];
    fmt = tgt_fmt[4*t +: 4];
    is_src = (t == int'(cmd_src));
    case (cmd_shorthand)
      2'd1: return is_src;
      2'd2: return 1'b1;
      2'd3: return !is_src;
      default: ;
    endcase
    if (!cmd_logical) return (cmd_dest == 8'hFF) || (cmd_dest == tgt_id[8*t +: 8]);
    if (fmt == 4'hF) return |(ldr & cmd_dest);
    if (fmt == 4'h0) return (ldr[7:4] == cmd_dest[7:4]) && |(ldr[3:0] & cmd_dest[3:0]);
    return 1'b0;
  endfunction

  // computes the expected mask and advances the model rotation
  function automatic logic [N-1:0] ref_mask();
    logic [N-1:0] m;
    for (int t = 0; t < N; t++) m[t] = ref_hit(t);
    if (!cmd_lowest) return m;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (rr_last + k) % N;
      if (m[j] && tgt_enable[j]) begin
        rr_last = j;
        return N'(1) << j;
      end
    end
    return '0;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, logic [7:0] d, logic lg, logic [1:0] sh,
                       logic lp, int src);
    logic [N-1:0] exp;
    @(negedge clk);
    cmd_dest = d; cmd_logical = lg; cmd_shorthand = sh;
    cmd_lowest = lp; cmd_src = IDXW'(src); cmd_valid = 1'b1;
    exp = ref_mask();
    @(negedge clk);
    cmd_valid = 1'b0;
    check({tag, " valid"}, N'(out_valid), N'(1));
    check(tag, out_mask, exp);
  endtask

  task automatic set_tgt(int t, logic [7:0] id, logic [7:0] ldr, logic [3:0] fmt, logic en);
    tgt_id[8*t +: 8] = id;
    tgt_ldr[8*t +: 8] = ldr;
    tgt_fmt[4*t +: 4] = fmt;
    tgt_enable[t] = en;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int t = 0; t < N; t++) set_tgt(t, 8'(t + 1), 8'(1 << t), 4'hF, 1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check("R1 reset valid", N'(out_valid), '0);
    // R1: first lowest-priority pick is index 0
    apply("R1 first rr", 8'hFF, 1'b0, 2'd0, 1'b1, 3);
    // R2
    apply("R2 broadcast", 8'hFF, 1'b0, 2'd0, 1'b0, 0);
    apply("R2 id hit", 8'd5, 1'b0, 2'd0, 1'b0, 0);
    apply("R2 id miss", 8'd77, 1'b0, 2'd0, 1'b0, 0);
    // R3, R4 with a destination that would hit others
    apply("R3 self", 8'hFF, 1'b0, 2'd1, 1'b0, 6);
    apply("R4 all", 8'd0, 1'b1, 2'd2, 1'b0, 2);
    apply("R4 allbut", 8'hFF, 1'b0, 2'd3, 1'b0, 2);
    // R5 flat
    apply("R5 flat", 8'b1010_0101, 1'b1, 2'd0, 1'b0, 0);
    // R6 cluster: targets 0..3 cluster 2, bits 0..3
    for (int t = 0; t < 4; t++) set_tgt(t, 8'(t), {4'h2, 4'(1 << t)}, 4'h0, 1'b1);
    apply("R6 cluster", 8'h26, 1'b1, 2'd0, 1'b0, 0);
    apply("R6 wrong cluster", 8'h36, 1'b1, 2'd0, 1'b0, 0);
    // R7 stray format nibble
    set_tgt(1, 8'd1, 8'h22, 4'h7, 1'b1);
    apply("R7 bad fmt", 8'h22, 1'b1, 2'd0, 1'b0, 0);
    // R8 rotation with wrap and skipping a disabled target
    for (int t = 0; t < N; t++) set_tgt(t, 8'(t), 8'hFF, 4'hF, 1'b1);
    tgt_enable[6] = 1'b0;
    for (int r = 0; r < 10; r++) apply("R8 rotate", 8'h01, 1'b1, 2'd0, 1'b1, 0);
    // R9 nothing qualifies, rotation unchanged
    tgt_enable = '0;
    apply("R9 none", 8'hFF, 1'b0, 2'd2, 1'b1, 0);
    tgt_enable = '1;
    apply("R9 rotation kept", 8'hFF, 1'b0, 2'd2, 1'b1, 0);
    // R10 stall
    begin
      logic [N-1:0] first;
      @(negedge clk);
      out_ready = 1'b0;
      cmd_dest = 8'd3; cmd_logical = 1'b0; cmd_shorthand = 2'd0;
      cmd_lowest = 1'b0; cmd_valid = 1'b1;
      first = ref_mask();
      @(negedge clk);
      check("R10 first", out_mask, first);
      cmd_dest = 8'd4;
      check("R10 ready low", N'(cmd_ready), '0);
      @(negedge clk);
      check("R10 held", out_mask, first);
      out_ready = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R10 second", out_mask, ref_mask());
    end
    // random mix
    for (int v = 0; v < 400; v++) begin
      string tag;
      for (int t = 0; t < N; t++) begin
        int f;
        f = $urandom_range(0, 4);
        set_tgt(t, 8'($urandom_range(0, 15)), 8'($urandom),
                (f < 2) ? 4'hF : (f < 4) ? 4'h0 : 4'($urandom), 1'($urandom));
      end
      cmd_lowest = 1'($urandom_range(0, 3) == 0);
      cmd_shorthand = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'd0;
      tag = cmd_lowest ? "R8 random" :
            (cmd_shorthand != 0) ? "R4 random" : "R2 R5 R6 random";
      apply(tag, ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 255)),
            1'($urandom), cmd_shorthand, cmd_lowest, $urandom_range(0, N - 1));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule